// File: doc/BRIEF.md
# Time-Redundant Upset Detector on a C-Slow Datapath

This block holds a small sequential datapath, a program-counter-style step plus a write-data register, that has been retimed into C pipeline slices. Each slice belongs to one of C independent threads. The threads share the logic in turn, one micro-cycle each, so one full step of a thread (a macro-cycle) takes C micro-cycles. A thread's input is taken in the same slice in which its state is presented at the outputs.

The surrounding system feeds every thread the same input during a macro-cycle. All threads also start from the same reset state, so they stay exact copies of one another. A single event upset will usually disturb only one thread. The block therefore compares the key state of each thread, its program counter and its write data, with the key state of the thread that owned the previous slice. Any difference sets a sticky upset flag. Comparison starts only once every thread has finished its first macro-cycle.

Top module: `cslow_seu_det`

## Requirements
- R1: While reset is held (asynchronous, active low), `thread_id` is 0, `pc_o` equals `INIT_PC`, `wdata_o` equals `INIT_DATA` and `seu_flag` is 0.
- R2: `thread_id` is 0 in the first micro-cycle after reset and then goes up by one every micro-cycle, wrapping from C-1 back to 0.
- R3: In micro-cycles 0 to C-1 after reset, every thread presents `pc_o = INIT_PC` and `wdata_o = INIT_DATA`.
- R4: A thread's `pc_o` in a slice equals its `pc_o` from C micro-cycles earlier plus `PC_INC`, modulo 2^PW.
- R5: A thread's `wdata_o` in a slice is derived from the values (p, w) it showed C micro-cycles earlier and the `din` (d) sampled in that earlier slice: x = w XOR d, then for r = 0 to C-1 in turn x = rotate-left-by-one(x) XOR zero-extend((p + r) mod 2^PW) (truncated when PW > DW); the final x is the new write data.
- R6: In a micro-cycle numbered C or later after reset in which `thread_id` is not 0, if {`pc_o`,`wdata_o`} differs from its value in the previous micro-cycle, `seu_flag` is 1 from the next micro-cycle on.
- R7: Once set, `seu_flag` stays 1 until reset.
- R8: `seu_flag` is 0 in micro-cycles 0 to C+1 after reset. It also stays 0 for as long as every thread receives the same `din` within each macro-cycle.
- R9: If one thread receives an input that differs in a single bit from its siblings', `seu_flag` rises no later than C micro-cycles after that thread first presents the corrupted write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Micro-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DW | Input of the thread owning the current slice |
| thread_id | output | max(1,clog2(C)) | Thread owning the current slice |
| pc_o | output | PW | Program counter of the current thread |
| wdata_o | output | DW | Write data of the current thread |
| seu_flag | output | 1 | Sticky upset flag |

## Verification
The bench corrupts a single bit of one thread's input in three places. Thread 0 is the hard case, because a wrong wrap pair would make the flag fire at every macro-cycle boundary or would never catch that thread. The last thread and a middle thread are also covered, and a compare that was off by one slice would miss these or flag late. Long runs with identical inputs show that no comparison fires while the threads still hold their reset copies. Running with every thread sharing the same input shows that a stage that dropped or misplaced a rotation, offset or increment changes the modelled outputs. A flag that cleared itself shows up in the checks after an injection, and one that survived reset shows up in the check taken during the following reset.

// File: rtl/cslow_pkg.sv
package cslow_pkg;
   localparam int unsigned MIN_SLOTS = 2;

   // width of a slot index for n threads
   function automatic int unsigned slot_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // width of a counter that must reach n
   function automatic int unsigned count_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/cslow_slot_ctr.sv
module cslow_slot_ctr #(
   parameter int unsigned C = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   output logic [cslow_pkg::slot_bits(C)-1:0]     tid,
   output logic                                   load_init,
   output logic                                   qual
);
   localparam int unsigned TW = cslow_pkg::slot_bits(C);
   localparam int unsigned CW = cslow_pkg::count_bits(C);

   logic [CW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tid   <= '0;
         age_q <= '0;
      end else begin
         tid <= (tid == TW'(C - 1)) ? '0 : tid + TW'(1);
         if (age_q != CW'(C))
            age_q <= age_q + CW'(1);
      end
   end

   // slots that have not finished a lap reload the start state
   assign load_init = (age_q < CW'(C - 1));
   // every thread has completed one macro-cycle
   assign qual      = (age_q == CW'(C));
endmodule

// File: rtl/cslow_stage.sv
module cslow_stage #(
   parameter int unsigned DW     = 16,
   parameter int unsigned PW     = 12,
   parameter int unsigned PC_INC = 4,
   parameter int unsigned IDX    = 0,
   parameter bit          LAST   = 1'b0
) (
   input  logic [PW-1:0] pc_i,
   input  logic [DW-1:0] w_i,
   output logic [PW-1:0] pc_o,
   output logic [DW-1:0] w_o
);
   logic [PW-1:0] pc_off;

   assign pc_off = pc_i + PW'(IDX);
   assign w_o    = {w_i[DW-2:0], w_i[DW-1]} ^ DW'(pc_off);

   generate
      if (LAST) begin : g_adv
         assign pc_o = pc_i + PW'(PC_INC);
      end else begin : g_pass
         assign pc_o = pc_i;
      end
   endgenerate
endmodule

// File: rtl/cslow_key_cmp.sv
module cslow_key_cmp #(
   parameter int unsigned KW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [KW-1:0] key,
   input  logic          cmp_en,
   output logic          seu_flag
);
   logic [KW-1:0] shadow_q;
   logic          differ;

   assign differ = cmp_en && (key != shadow_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         seu_flag <= 1'b0;
      end else begin
         shadow_q <= key;
         seu_flag <= seu_flag | differ;
      end
   end
endmodule

// File: rtl/cslow_seu_det.sv
module cslow_seu_det #(
   parameter int unsigned    C         = 3,
   parameter int unsigned    DW        = 16,
   parameter int unsigned    PW        = 12,
   parameter int unsigned    PC_INC    = 4,
   parameter logic [PW-1:0]  INIT_PC   = 'h100,
   parameter logic [DW-1:0]  INIT_DATA = 'hA5A5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [DW-1:0]                      din,
   output logic [cslow_pkg::slot_bits(C)-1:0] thread_id,
   output logic [PW-1:0]                      pc_o,
   output logic [DW-1:0]                      wdata_o,
   output logic                               seu_flag
);
   localparam int unsigned TW = cslow_pkg::slot_bits(C);
   localparam int unsigned KW = PW + DW;

   generate
      if (C < cslow_pkg::MIN_SLOTS) begin : g_bad_c
         $error("cslow_seu_det: C must be at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("cslow_seu_det: DW must be at least 2");
      end
      if (PW < 1) begin : g_bad_pw
         $error("cslow_seu_det: PW must be at least 1");
      end
      if (PC_INC >= (1 << PW)) begin : g_bad_inc
         $error("cslow_seu_det: PC_INC does not fit in PW bits");
      end
   endgenerate

   logic          load_init;
   logic          qual;
   logic [PW-1:0] lvl_pc [C];
   logic [DW-1:0] lvl_w  [C];
   logic [PW-1:0] nxt_pc [C];
   logic [DW-1:0] nxt_w  [C];
   logic [DW-1:0] stg_w  [C];

   cslow_slot_ctr #(.C(C)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .tid       (thread_id),
      .load_init (load_init),
      .qual      (qual)
   );

   // one stage per slice; the first stage mixes in the slot's input
   for (genvar k = 0; k < C; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign stg_w[k] = lvl_w[k] ^ din;
      end else begin : g_rest
         assign stg_w[k] = lvl_w[k];
      end
      cslow_stage #(
         .DW     (DW),
         .PW     (PW),
         .PC_INC (PC_INC),
         .IDX    (k),
         .LAST   (k == C - 1)
      ) u_stg (
         .pc_i (lvl_pc[k]),
         .w_i  (stg_w[k]),
         .pc_o (nxt_pc[k]),
         .w_o  (nxt_w[k])
      );
   end

   // level 0 is the original register, levels 1..C-1 the retiming registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_pc[0] <= INIT_PC;
         lvl_w[0]  <= INIT_DATA;
         for (int j = 1; j < C; j++) begin
            lvl_pc[j] <= '0;
            lvl_w[j]  <= '0;
         end
      end else begin
         lvl_pc[0] <= load_init ? INIT_PC   : nxt_pc[C-1];
         lvl_w[0]  <= load_init ? INIT_DATA : nxt_w[C-1];
         for (int j = 1; j < C; j++) begin
            lvl_pc[j] <= nxt_pc[j-1];
            lvl_w[j]  <= nxt_w[j-1];
         end
      end
   end

   assign pc_o    = lvl_pc[0];
   assign wdata_o = lvl_w[0];

   cslow_key_cmp #(.KW(KW)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .key      ({lvl_pc[0], lvl_w[0]}),
      .cmp_en   (qual && (thread_id != TW'(0))),
      .seu_flag (seu_flag)
   );
endmodule

// File: rtl/cslow_seu_chk.sv
module cslow_seu_chk #(
   parameter int unsigned    C         = 3,
   parameter int unsigned    DW        = 16,
   parameter int unsigned    PW        = 12,
   parameter logic [PW-1:0]  INIT_PC   = 'h100,
   parameter logic [DW-1:0]  INIT_DATA = 'hA5A5
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [cslow_pkg::slot_bits(C)-1:0] tid,
   input logic [PW-1:0]                      pc,
   input logic [DW-1:0]                      w,
   input logic                               flag
);
   localparam int unsigned TW  = cslow_pkg::slot_bits(C);
   localparam int unsigned NW  = cslow_pkg::count_bits(C + 2);

   logic [NW-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_q <= '0;
      else if (since_q != NW'(C + 2))
         since_q <= since_q + NW'(1);
   end

   p_tid_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tid == TW'(C - 1)) |=> (tid == '0));

   p_tid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tid != TW'(C - 1)) |=> (tid == $past(tid) + TW'(1)));

   p_first_lap_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q < NW'(C)) |-> (pc == INIT_PC && w == INIT_DATA));

   p_diff_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q >= NW'(C) && tid != '0 && {pc, w} != {$past(pc), $past(w)}) |=> flag);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> flag);

   p_no_early_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q <= NW'(C + 1)) |-> !flag);
endmodule

bind cslow_seu_det cslow_seu_chk #(
   .C         (C),
   .DW        (DW),
   .PW        (PW),
   .INIT_PC   (INIT_PC),
   .INIT_DATA (INIT_DATA)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tid   (thread_id),
   .pc    (pc_o),
   .w     (wdata_o),
   .flag  (seu_flag)
);

// File: tb/tb_cslow_seu_det.sv
module tb_cslow_seu_det;
   localparam int unsigned   C         = 3;
   localparam int unsigned   DW        = 16;
   localparam int unsigned   PW        = 12;
   localparam int unsigned   PC_INC    = 4;
   localparam logic [PW-1:0] INIT_PC   = 12'h100;
   localparam logic [DW-1:0] INIT_DATA = 16'hA5A5;
   localparam int unsigned   TW        = cslow_pkg::slot_bits(C);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [TW-1:0] thread_id;
   logic [PW-1:0] pc_o;
   logic [DW-1:0] wdata_o;
   logic          seu_flag;

   always #4 clk = ~clk;

   cslow_seu_det #(
      .C(C), .DW(DW), .PW(PW), .PC_INC(PC_INC),
      .INIT_PC(INIT_PC), .INIT_DATA(INIT_DATA)
   ) dut (
      .clk(clk), .rst_n(rst_n), .din(din), .thread_id(thread_id),
      .pc_o(pc_o), .wdata_o(wdata_o), .seu_flag(seu_flag)
   );

   int unsigned   n_chk  = 0;
   int unsigned   n_fail = 0;
   bit            done   = 1'b0;
   int unsigned   mc;
   logic [PW-1:0] st_pc [C];
   logic [DW-1:0] st_w  [C];
   logic [PW-1:0] prev_pc;
   logic [DW-1:0] prev_w;
   logic          exp_flag;

   function automatic logic [PW-1:0] model_pc(input logic [PW-1:0] p);
      return p + PW'(PC_INC);
   endfunction

   function automatic logic [DW-1:0] model_w(input logic [PW-1:0] p,
                                             input logic [DW-1:0] w,
                                             input logic [DW-1:0] d);
      logic [DW-1:0] x;
      logic [PW-1:0] s;
      x = w ^ d;
      for (int r = 0; r < C; r++) begin
         s = p + PW'(r);
         x = {x[DW-2:0], x[DW-1]} ^ DW'(s);
      end
      return x;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge with reset held; releases it at the end
   task automatic do_reset();
      rst_n = 1'b0;
      din   = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(thread_id == '0,       "R1 tid",   32'(thread_id), 32'd0);
      chk(pc_o == INIT_PC,       "R1 pc",    32'(pc_o),      32'(INIT_PC));
      chk(wdata_o == INIT_DATA,  "R1 wdata", 32'(wdata_o),   32'(INIT_DATA));
      chk(seu_flag == 1'b0,      "R1 flag",  32'(seu_flag),  32'd0);
      rst_n = 1'b1;
      mc = 0;
      exp_flag = 1'b0;
      for (int t = 0; t < C; t++) begin
         st_pc[t] = INIT_PC;
         st_w[t]  = INIT_DATA;
      end
   endtask

   // one micro-cycle: check slot mc, apply d, advance to next negedge
   task automatic step(input logic [DW-1:0] d);
      int unsigned t;
      logic        mism;
      t = mc % C;
      chk(thread_id == TW'(t), "R2 tid", 32'(thread_id), 32'(t));
      chk(pc_o == st_pc[t], (mc < C) ? "R3 pc" : "R4 pc", 32'(pc_o), 32'(st_pc[t]));
      chk(wdata_o == st_w[t], (mc < C) ? "R3 wdata" : "R5 wdata",
          32'(wdata_o), 32'(st_w[t]));
      chk(seu_flag == exp_flag, exp_flag ? "R7 flag" : "R8 flag",
          32'(seu_flag), 32'(exp_flag));
      mism = (mc >= C) && (t != 0) && ({st_pc[t], st_w[t]} != {prev_pc, prev_w});
      if (mism) exp_flag = 1'b1;   // R6: visible from the next slice
      prev_pc  = st_pc[t];
      prev_w   = st_w[t];
      st_w[t]  = model_w(st_pc[t], st_w[t], d);
      st_pc[t] = model_pc(st_pc[t]);
      din = d;
      mc++;
      @(posedge clk);
      @(negedge clk);
   endtask

   // one macro-cycle, same input to every slot except an optional flip
   task automatic macro(input logic [DW-1:0] d, input int inj_t, input int inj_b);
      for (int t = 0; t < C; t++)
         step((t == inj_t) ? (d ^ (DW'(1) << inj_b)) : d);
   endtask

   task automatic inject_case(input int victim, input int pre);
      int b;
      for (int i = 0; i < pre; i++) macro(DW'($urandom), -1, 0);
      b = int'($urandom_range(DW - 1, 0));
      macro(DW'($urandom), victim, b);
      macro(DW'($urandom), -1, 0);
      // corrupted data shown in the slot just passed; flag due by now
      chk(seu_flag == 1'b1, "R9 detect", 32'(seu_flag), 32'd1);
      for (int i = 0; i < 4; i++) macro(DW'($urandom), -1, 0);
      chk(seu_flag == 1'b1, "R7 hold", 32'(seu_flag), 32'd1);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      @(negedge clk);
      do_reset();
      // directed corners with identical inputs
      macro('0, -1, 0);
      macro('1, -1, 0);
      macro(DW'(16'h8000), -1, 0);
      // random identical inputs: no flag allowed (R8), state tracks R4/R5
      for (int i = 0; i < 40; i++) macro(DW'($urandom), -1, 0);
      chk(seu_flag == 1'b0, "R8 clean run", 32'(seu_flag), 32'd0);
      // middle thread upset
      inject_case(1, 0);
      // reset clears the sticky flag (R1 checks inside)
      do_reset();
      inject_case(0, 5);       // wrap-pair corner
      do_reset();
      inject_case(C - 1, 7);   // last slot
      do_reset();
      for (int i = 0; i < 20; i++) macro(DW'($urandom), -1, 0);
      chk(seu_flag == 1'b0, "R8 after reset", 32'(seu_flag), 32'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule